// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the SCL timing of an I2C bus master. It holds one high-count and one low-count register for each bus speed (standard and fast by default) and a speed field that picks which pair drives the bus. Software disables the block, programs the counts, and enables it again. A start request then runs the START hold interval. After that the block alternates driven-low and released-high SCL phases until a stop request is seen at the end of a high phase.

The low phase is timed from the cycle in which the block itself pulls SCL low. It does not wait for SCL to be observed low. Each phase adds a fixed overhead of cycles to its programmed count, so firmware can calculate bus timing from the input clock frequency. The current phase and a master-activity flag are visible at the ports for the surrounding master logic.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, `scl_drive_low_o` is 0, `busy_o` is 0 and `phase_o` is 0 (idle). Every count register and the speed field reset to 0.
- R2: Writes use `wr_sel_i`: 0 = standard high count, 1 = standard low count, 2 = fast high count, 3 = fast low count, 4 = speed field. For the speed field, `wr_data_i` 0 selects standard and 1 selects fast. At the start of a transfer, the pair named by the speed field is the one used.
- R3: If the block is idle with `en_i` high, `start_req_i` moves it to the START hold phase (`phase_o` = 1) in the next cycle, with SCL released. This phase lasts H+3 cycles, where H is the selected high count.
- R4: The low phase (`phase_o` = 2) drives `scl_drive_low_o` high from its first cycle and lasts L+1 cycles, where L is the selected low count. `scl_drive_low_o` is high only in this phase.
- R5: The high phase (`phase_o` = 3) releases SCL and lasts H+8 cycles.
- R6: The START hold phase is followed by a low phase, and each high phase is followed by another low phase. The exception: if a stop request has been seen in any cycle of the transfer so far, the block returns to idle when the high phase ends.
- R7: `busy_o` is high exactly while `phase_o` is not 0.
- R8: The speed field is sampled only when a transfer starts. A speed write is accepted even while enabled, but it changes only the next transfer.
- R9: Count register writes are accepted only while `en_i` is low. Writes made while `en_i` is high leave the counts unchanged.
- R10: A high count below HI_MIN (6) acts as HI_MIN. A low count below LO_MIN (8) acts as LO_MIN.
- R11: When `en_i` is low, the block is idle (phase 0, SCL released) from the next cycle on. Any pending stop request is discarded.
- R12: `start_req_i` has no effect while `en_i` is low or while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; all phase lengths count its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low forces idle and opens count writes |
| start_req_i | input | 1 | Request to begin a transfer with a START hold phase |
| stop_req_i | input | 1 | Request to end the transfer after the current high phase |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (see R2) |
| wr_data_i | input | 16 | Register write data |
| scl_drive_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| busy_o | output | 1 | Master activity flag |
| phase_o | output | 2 | 0 idle, 1 START hold, 2 low, 3 high |

## Verification
The bench builds the block with 8-bit counts and the default minimums of 6 and 8. This makes the full count range small enough to sweep in short runs. It steps both speed pairs through counts below, at and above each minimum, plus the all-ones maximum. Every phase length is compared against the arithmetic H+3, L+1 and H+8. The small width also keeps short the mid-transfer cases: a speed change, a locked-out count write, a disable with a stop request pending, and ignored starts.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HOLD = 2'd1,
      PH_LOW  = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;

   // fixed overhead added to the programmed counts
   localparam int unsigned HOLD_EXTRA = 3;
   localparam int unsigned LOW_EXTRA  = 1;
   localparam int unsigned HIGH_EXTRA = 8;

endpackage

// File: rtl/scl_cnt_regs.sv
module scl_cnt_regs #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned N_MODES = 2,
   localparam int unsigned SPD_W  = (N_MODES > 1) ? $clog2(N_MODES) : 1,
   localparam int unsigned SEL_W  = $clog2(2 * N_MODES + 1)
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            en_i,
   input  logic                            wr_en_i,
   input  logic [SEL_W-1:0]                wr_sel_i,
   input  logic [CNT_W-1:0]                wr_data_i,
   output logic [N_MODES-1:0][CNT_W-1:0]   hi_o,
   output logic [N_MODES-1:0][CNT_W-1:0]   lo_o,
   output logic [SPD_W-1:0]                spd_o
);

   localparam logic [SEL_W-1:0] SPD_SEL = SEL_W'(2 * N_MODES);

   logic [N_MODES-1:0][CNT_W-1:0] hi_q, lo_q;
   logic [SPD_W-1:0]              spd_q;

   for (genvar m = 0; m < N_MODES; m++) begin : g_mode
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hi_q[m] <= '0;
            lo_q[m] <= '0;
         end else if (wr_en_i && !en_i) begin
            if (wr_sel_i == SEL_W'(2 * m))     hi_q[m] <= wr_data_i;
            if (wr_sel_i == SEL_W'(2 * m + 1)) lo_q[m] <= wr_data_i;
         end
      end
   end

   // speed field stays writable while enabled; the phase engine samples it at START
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         spd_q <= '0;
      else if (wr_en_i && wr_sel_i == SPD_SEL && wr_data_i < CNT_W'(N_MODES))
         spd_q <= wr_data_i[SPD_W-1:0];
   end

   assign hi_o  = hi_q;
   assign lo_o  = lo_q;
   assign spd_o = spd_q;

   // R9: count registers locked while enabled
   p_cnt_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && en_i) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_gen_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned N_MODES = 2,
   parameter int unsigned HI_MIN  = 6,
   parameter int unsigned LO_MIN  = 8,
   localparam int unsigned SPD_W  = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            en_i,
   input  logic                            start_req_i,
   input  logic                            stop_req_i,
   input  logic [N_MODES-1:0][CNT_W-1:0]   hi_i,
   input  logic [N_MODES-1:0][CNT_W-1:0]   lo_i,
   input  logic [SPD_W-1:0]                spd_i,
   output scl_phase_e                      phase_o,
   output logic                            busy_o,
   output logic                            scl_low_o
);

   localparam int unsigned PH_W  = CNT_W + 4;
   localparam int unsigned RUN_W = PH_W + 1;

   scl_phase_e       state_q, state_d;
   logic [PH_W-1:0]  cnt_q, cnt_d;
   logic [CNT_W-1:0] hi_act_q, hi_act_d, lo_act_q, lo_act_d;
   logic [CNT_W-1:0] hi_sel, lo_sel, hi_clamp, lo_clamp;
   logic             stop_pend_q, stop_pend_d;

   assign hi_sel   = hi_i[spd_i];
   assign lo_sel   = lo_i[spd_i];
   assign hi_clamp = (hi_sel < CNT_W'(HI_MIN)) ? CNT_W'(HI_MIN) : hi_sel;
   assign lo_clamp = (lo_sel < CNT_W'(LO_MIN)) ? CNT_W'(LO_MIN) : lo_sel;

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      hi_act_d = hi_act_q;
      lo_act_d = lo_act_q;
      if (!en_i) begin
         state_d = PH_IDLE;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            PH_IDLE: if (start_req_i) begin
               state_d  = PH_HOLD;
               hi_act_d = hi_clamp;
               lo_act_d = lo_clamp;
               cnt_d    = PH_W'(hi_clamp) + PH_W'(HOLD_EXTRA - 1);
            end
            PH_HOLD, PH_HIGH: if (cnt_q != '0) begin
               cnt_d = cnt_q - 1'b1;
            end else if (state_q == PH_HIGH && (stop_pend_q || stop_req_i)) begin
               state_d = PH_IDLE;
            end else begin
               state_d = PH_LOW;
               cnt_d   = PH_W'(lo_act_q) + PH_W'(LOW_EXTRA - 1);
            end
            PH_LOW: if (cnt_q != '0) begin
               cnt_d = cnt_q - 1'b1;
            end else begin
               state_d = PH_HIGH;
               cnt_d   = PH_W'(hi_act_q) + PH_W'(HIGH_EXTRA - 1);
            end
            default: state_d = PH_IDLE;
         endcase
      end
   end

   assign stop_pend_d = (state_q != PH_IDLE) && (state_d != PH_IDLE)
                        && (stop_pend_q || stop_req_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= PH_IDLE;
         cnt_q       <= '0;
         hi_act_q    <= CNT_W'(HI_MIN);
         lo_act_q    <= CNT_W'(LO_MIN);
         stop_pend_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         cnt_q       <= cnt_d;
         hi_act_q    <= hi_act_d;
         lo_act_q    <= lo_act_d;
         stop_pend_q <= stop_pend_d;
      end
   end

   assign phase_o   = state_q;
   assign busy_o    = (state_q != PH_IDLE);
   assign scl_low_o = (state_q == PH_LOW);

   // independent run-length counter for the length checks
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] hold_len, low_len, high_len;
   assign hold_len = RUN_W'(hi_act_q) + RUN_W'(HOLD_EXTRA);
   assign low_len  = RUN_W'(lo_act_q) + RUN_W'(LOW_EXTRA);
   assign high_len = RUN_W'(hi_act_q) + RUN_W'(HIGH_EXTRA);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 run_q <= RUN_W'(1);
      else if (state_d != state_q) run_q <= RUN_W'(1);
      else                         run_q <= run_q + 1'b1;
   end

   p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && state_q == PH_IDLE && start_req_i) |=> state_q == PH_HOLD);
   p_hold_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && state_q == PH_HOLD && run_q == hold_len) |=> state_q == PH_LOW);
   p_low_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && state_q == PH_LOW && run_q == low_len) |=> state_q == PH_HIGH);
   p_low_early_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && state_q == PH_LOW && run_q < low_len) |=> state_q == PH_LOW);
   p_high_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && state_q == PH_HIGH && run_q == high_len) |=> state_q != PH_HIGH);
   p_busy_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> ($past(state_q) == PH_HIGH || !$past(en_i)));
   p_act_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != PH_IDLE) |=> ($stable(hi_act_q) && $stable(lo_act_q)));
   p_clamp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != PH_IDLE) |-> (hi_act_q >= CNT_W'(HI_MIN) && lo_act_q >= CNT_W'(LO_MIN)));
   p_disable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (state_q == PH_IDLE && !stop_pend_q));

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
   import scl_gen_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned N_MODES = 2,
   parameter int unsigned HI_MIN  = 6,
   parameter int unsigned LO_MIN  = 8,
   localparam int unsigned SEL_W  = $clog2(2 * N_MODES + 1),
   localparam int unsigned SPD_W  = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             start_req_i,
   input  logic             stop_req_i,
   input  logic             wr_en_i,
   input  logic [SEL_W-1:0] wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic             scl_drive_low_o,
   output logic             busy_o,
   output logic [1:0]       phase_o
);

   if (CNT_W < 4 || CNT_W > 28) begin : g_bad_width
      $error("scl_period_gen: CNT_W must lie in 4..28");
   end
   if (N_MODES < 1 || N_MODES > 8) begin : g_bad_modes
      $error("scl_period_gen: N_MODES must lie in 1..8");
   end
   if (HI_MIN < 1 || HI_MIN >= (1 << CNT_W) || LO_MIN < 1 || LO_MIN >= (1 << CNT_W)) begin : g_bad_min
      $error("scl_period_gen: minimum counts must fit in CNT_W and be nonzero");
   end

   logic [N_MODES-1:0][CNT_W-1:0] hi_w, lo_w;
   logic [SPD_W-1:0]              spd_w;
   scl_phase_e                    phase_w;

   scl_cnt_regs #(
      .CNT_W   (CNT_W),
      .N_MODES (N_MODES)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .hi_o      (hi_w),
      .lo_o      (lo_w),
      .spd_o     (spd_w)
   );

   scl_phase_fsm #(
      .CNT_W   (CNT_W),
      .N_MODES (N_MODES),
      .HI_MIN  (HI_MIN),
      .LO_MIN  (LO_MIN)
   ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_i),
      .start_req_i (start_req_i),
      .stop_req_i  (stop_req_i),
      .hi_i        (hi_w),
      .lo_i        (lo_w),
      .spd_i       (spd_w),
      .phase_o     (phase_w),
      .busy_o      (busy_o),
      .scl_low_o   (scl_drive_low_o)
   );

   assign phase_o = phase_w;

   // R4: SCL is pulled low only in the low phase
   p_drive_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      scl_drive_low_o |-> (phase_o == 2'd2));

endmodule

// File: tb/scl_period_gen_tb_top.sv
`timescale 1ns/1ps
module scl_period_gen_tb_top;

   localparam int CW   = 8;
   localparam int HMIN = 6;
   localparam int LMIN = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          start_req = 1'b0;
   logic          stop_req = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [CW-1:0] wr_data = '0;
   logic          scl_low, busy;
   logic [1:0]    phase;
   int            total = 0;
   int            bad = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   scl_period_gen #(.CNT_W(CW), .N_MODES(2), .HI_MIN(HMIN), .LO_MIN(LMIN)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_req_i(start_req),
      .stop_req_i(stop_req), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .scl_drive_low_o(scl_low), .busy_o(busy),
      .phase_o(phase)
   );

   function automatic int eff(input int v, input int mn);
      return (v < mn) ? mn : v;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] s, input int d);
      wr_en = 1'b1; wr_sel = s; wr_data = CW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // counts consecutive samples of one phase, checking outputs each cycle
   task automatic run_len(input logic [1:0] ph, input int n0, output int n);
      n = n0;
      while (phase == ph && n < 2000) begin
         check(scl_low == (phase == 2'd2), "R4_drive", int'(scl_low), int'(phase == 2'd2));
         check(busy == (phase != 2'd0), "R7_busy", int'(busy), int'(phase != 2'd0));
         n++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_start();
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic configure(input int m, input int h, input int l, input int oh, input int ol);
      en = 1'b0;
      @(negedge clk);
      wr(3'(2 * m), h);
      wr(3'(2 * m + 1), l);
      wr(3'(2 * (1 - m)), oh);
      wr(3'(2 * (1 - m) + 1), ol);
      wr(3'd4, m);
      en = 1'b1;
      @(negedge clk);
   endtask

   // one transfer: hold, low, high, low (stop pulse), high, idle
   task automatic xfer(input int he, input int le);
      int n;
      pulse_start();
      run_len(2'd1, 0, n); check(n == he + 3, "R3_hold_len", n, he + 3);
      run_len(2'd2, 0, n); check(n == le + 1, "R4_low_len", n, le + 1);
      run_len(2'd3, 0, n); check(n == he + 8, "R5_high_len", n, he + 8);
      check(phase == 2'd2, "R6_relow", int'(phase), 2);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      run_len(2'd2, 1, n); check(n == le + 1, "R4_low2_len", n, le + 1);
      run_len(2'd3, 0, n); check(n == he + 8, "R5_high2_len", n, he + 8);
      check(phase == 2'd0, "R6_stop_idle", int'(phase), 0);
      check(busy == 1'b0, "R7_idle_busy", int'(busy), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(phase == 2'd0, "R1_phase", int'(phase), 0);
      check(busy == 1'b0, "R1_busy", int'(busy), 0);
      check(scl_low == 1'b0, "R1_scl", int'(scl_low), 0);
      // R1/R10: reset counts are zero, so minimums apply
      en = 1'b1;
      @(negedge clk);
      xfer(HMIN, LMIN);

      // R2/R3/R4/R5/R10 sweep across both pairs
      for (int m = 0; m < 2; m++) begin
         for (int k = 0; k < 12; k++) begin
            int h = 2 * k + m;
            int l = (5 * k + 3) % 23;
            configure(m, h, l, h + 40, l + 50);
            xfer(eff(h, HMIN), eff(l, LMIN));
         end
      end
      configure(1, 255, 255, 9, 9);
      xfer(255, 255);

      // R8: speed change mid-transfer only takes effect at next START
      configure(0, 10, 12, 20, 30);
      pulse_start();
      run_len(2'd1, 0, n);
      wr(3'd4, 1);
      run_len(2'd2, 1, n); check(n == 13, "R8_low_keep", n, 13);
      run_len(2'd3, 0, n); check(n == 18, "R8_high_keep", n, 18);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      run_len(2'd2, 1, n);
      run_len(2'd3, 0, n);
      check(phase == 2'd0, "R8_idle", int'(phase), 0);
      xfer(20, 30);

      // R9: count writes while enabled are dropped
      configure(0, 11, 14, 7, 9);
      wr(3'd0, 30);
      wr(3'd1, 40);
      xfer(11, 14);

      // R11: disable mid-transfer with a stop pending
      pulse_start();
      run_len(2'd1, 0, n);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      en = 1'b0;
      @(negedge clk);
      check(phase == 2'd0, "R11_phase", int'(phase), 0);
      check(scl_low == 1'b0, "R11_scl", int'(scl_low), 0);
      check(busy == 1'b0, "R11_busy", int'(busy), 0);
      en = 1'b1;
      @(negedge clk);
      pulse_start();
      run_len(2'd1, 0, n);
      run_len(2'd2, 0, n);
      run_len(2'd3, 0, n);
      check(phase == 2'd2, "R11_stop_dropped", int'(phase), 2);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      run_len(2'd2, 1, n);
      run_len(2'd3, 0, n);

      // R12: start ignored while disabled
      en = 1'b0;
      @(negedge clk);
      pulse_start();
      check(phase == 2'd0, "R12_disabled", int'(phase), 0);
      // R12: start ignored while busy
      en = 1'b1;
      @(negedge clk);
      pulse_start();
      run_len(2'd1, 0, n);
      run_len(2'd2, 0, n);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      check(phase == 2'd3, "R12_busy_start", int'(phase), 3);
      run_len(2'd3, 1, n); check(n == 19, "R12_high_len", n, 19);
      run_len(2'd2, 0, n); check(n == 15, "R12_low_len", n, 15);
      stop_req = 1'b1;
      run_len(2'd3, 0, n);
      stop_req = 1'b0;
      check(phase == 2'd0, "R6_final_idle", int'(phase), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule